// File: doc/BRIEF.md
# Store Address Queue with Load Conflict Check

This block holds the addresses of stores that have left the execute stage but have not yet been written to the data cache. Stores enter in program order and carry a one-bit tag that names the store-data queue holding their data: the integer queue or the floating-point queue. A store becomes eligible for the cache only when three things are true. It is the oldest entry, the commit logic has marked it committed, and its data queue reports valid data. When the cache accepts it, the block pops the matching data queue in that same cycle.

Loads check their address against every valid entry, committed or not. The compare ignores the low `GRAN_LG2` address bits, which gives 8-byte granules by default. A load that hits no entry may proceed ahead of the older stores. A load that hits an entry is flagged for replay and gets no forwarded data.

A pipeline flush discards every entry not yet committed and keeps the committed ones. The store-address enqueue and the store issue follow valid/ready rules. An enqueue transfers on a cycle where `enq_valid` and `enq_ready` are both high and `flush` is low. `enq_ready` is low while all `DEPTH` entries are in use. A store issues on a cycle where `st_valid` and `st_ready` are both high. The load check is a single-cycle lookup with no handshake.

Top module: `store_addr_queue`

## Requirements
- R1: After reset the queue is empty. `enq_ready` is 1, `st_valid` is 0, and any load is allowed to proceed.
- R2: `enq_ready` is 0 while `DEPTH` (default 4) entries are held. An enqueue offered while full is dropped and leaves no entry behind.
- R3: Stores go to the cache strictly in enqueue order. `st_addr` and `st_is_fp` always show the oldest entry.
- R4: `st_valid` is 1 only when the oldest entry is committed and the data queue its tag selects has valid data. Tag 0 selects the integer queue (`idata_valid`) and tag 1 selects the floating-point queue (`fdata_valid`). Valid data on the other queue does not count.
- R5: `idata_ready` is 1 exactly in a cycle where an integer-tagged store issues (`st_valid` and `st_ready` both 1). `fdata_ready` behaves the same way for floating-point-tagged stores. Neither is 1 in any other cycle.
- R6: A load whose address bits [AW-1:GRAN_LG2] equal those of any valid entry gives `ld_replay`=1 and `ld_proceed`=0 in the same cycle. When `ld_valid` is 0, both outputs are 0.
- R7: A load that matches no valid entry gives `ld_proceed`=1 even when older stores are queued. Addresses in adjacent granules do not match. A store enqueued in the same cycle is not yet visible to the load.
- R8: A `commit` pulse marks the oldest entry that is not yet committed. A pulse when no such entry exists, including one in the cycle that enqueues the store, is ignored.
- R9: `flush` removes all uncommitted entries and keeps the committed ones. An enqueue offered in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store address offered |
| enq_ready | output | 1 | Queue can accept an address |
| enq_addr | input | AW | Store address |
| enq_is_fp | input | 1 | Data source tag: 1 = floating-point queue |
| commit | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Drop all uncommitted stores |
| idata_valid | input | 1 | Integer store-data queue has data |
| idata_ready | output | 1 | Pop the integer store-data queue |
| fdata_valid | input | 1 | Floating-point store-data queue has data |
| fdata_ready | output | 1 | Pop the floating-point store-data queue |
| ld_valid | input | 1 | Load address presented for checking |
| ld_addr | input | AW | Load address |
| ld_replay | output | 1 | Load conflicts with a queued store |
| ld_proceed | output | 1 | Load may bypass queued stores |
| st_valid | output | 1 | Oldest store is ready for the cache |
| st_ready | input | 1 | Cache accepts the store |
| st_addr | output | AW | Address of the oldest store |
| st_is_fp | output | 1 | Data source tag of the oldest store |

## Verification
The bench targets several corner cases.

- A commit arriving in the same cycle as an enqueue must not mark the new store. A design that got this wrong would issue a store that had never been committed.
- A store tagged for one data queue is offered valid data only on the other queue. A design that got this wrong would pop the wrong queue and pair the address with foreign data.
- A flush arrives while the queue holds a mix of committed and uncommitted entries, with an enqueue offered in the same cycle. A design that got this wrong would lose a committed store or keep a dead one. A dead entry shows up as a later load being replayed against an address that was flushed.
- Load probes sit one byte inside a granule and one granule beyond it, and the full queue is drained across the pointer wrap. These catch a wrong compare width and broken ordering.

// File: rtl/saq_pkg.sv
package saq_pkg;
  // Which store-data queue supplies an entry's data.
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_FP  = 1'b1
  } dsrc_e;
endpackage

// File: rtl/saq_ctrl.sv
// Ring pointers and occupancy counters for the store address queue.
module saq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_fire,
  input  logic          pop,
  input  logic          cmt_req,
  input  logic          flush,
  output logic          cmt_fire,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] cptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] ncmt
);
  logic [PW-1:0] head_n, tail_n;
  logic [CW-1:0] count_n, ncmt_n;

  // A commit needs an uncommitted entry that already exists.
  assign cmt_fire = cmt_req && (count > ncmt);
  assign cptr     = PW'((int'(head) + int'(ncmt)) % DEPTH);

  always_comb begin
    int h, n, c, t;
    n = int'(ncmt) + (cmt_fire ? 1 : 0) - (pop ? 1 : 0);
    h = int'(head) + (pop ? 1 : 0);
    if (h >= DEPTH) h = h - DEPTH;
    if (flush) begin
      c = n;
      t = (h + n) % DEPTH;
    end else begin
      c = int'(count) + (enq_fire ? 1 : 0) - (pop ? 1 : 0);
      t = (int'(tail) + (enq_fire ? 1 : 0)) % DEPTH;
    end
    head_n  = PW'(h);
    tail_n  = PW'(t);
    count_n = CW'(c);
    ncmt_n  = CW'(n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      ncmt  <= '0;
    end else begin
      head  <= head_n;
      tail  <= tail_n;
      count <= count_n;
      ncmt  <= ncmt_n;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r8_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ncmt <= count);
endmodule

// File: rtl/saq_cam.sv
// Associative compare of a load address against every valid entry.
module saq_cam #(
  parameter int DEPTH    = 4,
  parameter int AW       = 32,
  parameter int GRAN_LG2 = 3
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] addrs,
  input  logic [AW-1:0]            probe,
  output logic                     hit
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (addrs[i][AW-1:GRAN_LG2] == probe[AW-1:GRAN_LG2]);
  end

  assign hit = |match;
endmodule

// File: rtl/saq_issue.sv
// Head issue gating and data-queue pop selection.
module saq_issue (
  input  logic head_cmt,
  input  logic head_fp,
  input  logic idata_valid,
  input  logic fdata_valid,
  input  logic st_ready,
  output logic st_valid,
  output logic pop,
  output logic idata_ready,
  output logic fdata_ready
);
  logic data_here;

  assign data_here   = head_fp ? fdata_valid : idata_valid;
  assign st_valid    = head_cmt && data_here;
  assign pop         = st_valid && st_ready;
  assign idata_ready = pop && !head_fp;
  assign fdata_ready = pop && head_fp;
endmodule

// File: rtl/store_addr_queue.sv
module store_addr_queue
  import saq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int AW       = 32,
  parameter int GRAN_LG2 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [AW-1:0] enq_addr,
  input  logic          enq_is_fp,
  input  logic          commit,
  input  logic          flush,
  input  logic          idata_valid,
  output logic          idata_ready,
  input  logic          fdata_valid,
  output logic          fdata_ready,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_replay,
  output logic          ld_proceed,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [AW-1:0] st_addr,
  output logic          st_is_fp
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] head, tail, cptr;
  logic [CW-1:0] count, ncmt;
  logic          enq_fire, pop, cmt_fire, ld_hit;

  logic [DEPTH-1:0]         vld, cmt;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  dsrc_e                    src_q [DEPTH];

  assign enq_ready = (count < CW'(DEPTH));
  assign enq_fire  = enq_valid && enq_ready && !flush;

  saq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enq_fire(enq_fire), .pop(pop),
    .cmt_req(commit), .flush(flush), .cmt_fire(cmt_fire),
    .head(head), .tail(tail), .cptr(cptr), .count(count), .ncmt(ncmt)
  );

  // Entry storage: valid, committed, address and data-source tag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      cmt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        src_q[i]  <= SRC_INT;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        logic pop_hit, cmt_nx;
        pop_hit = pop && (head == PW'(i));
        cmt_nx  = (cmt[i] || (cmt_fire && cptr == PW'(i))) && !pop_hit;
        if (enq_fire && tail == PW'(i)) begin
          vld[i]    <= 1'b1;
          cmt[i]    <= 1'b0;
          addr_q[i] <= enq_addr;
          src_q[i]  <= enq_is_fp ? SRC_FP : SRC_INT;
        end else begin
          vld[i] <= vld[i] && !pop_hit && !(flush && !cmt_nx);
          cmt[i] <= cmt_nx;
        end
      end
    end
  end

  saq_cam #(.DEPTH(DEPTH), .AW(AW), .GRAN_LG2(GRAN_LG2)) u_cam (
    .vld(vld), .addrs(addr_q), .probe(ld_addr), .hit(ld_hit)
  );

  assign ld_replay  = ld_valid && ld_hit;
  assign ld_proceed = ld_valid && !ld_hit;

  assign st_addr  = addr_q[head];
  assign st_is_fp = (src_q[head] == SRC_FP);

  saq_issue u_issue (
    .head_cmt(cmt[head]), .head_fp(st_is_fp),
    .idata_valid(idata_valid), .fdata_valid(fdata_valid),
    .st_ready(st_ready), .st_valid(st_valid), .pop(pop),
    .idata_ready(idata_ready), .fdata_ready(fdata_ready)
  );

  a_r2_bits_match_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == int'(count));
  a_r4_issue_committed: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (vld[head] && cmt[head]));
  a_r5_int_pop_rule: assert property (@(posedge clk) disable iff (!rst_n)
    idata_ready |-> (st_valid && st_ready && !st_is_fp));
  a_r5_fp_pop_rule: assert property (@(posedge clk) disable iff (!rst_n)
    fdata_ready |-> (st_valid && st_ready && st_is_fp));
  a_r6_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ld_replay |-> (ld_valid && !ld_proceed));
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> ((vld & ~cmt) == '0));
endmodule

// File: tb/sim_store_addr_queue.sv
`timescale 1ns/1ps
module sim_store_addr_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid, enq_ready, enq_is_fp, commit, flush;
  logic [31:0] enq_addr, ld_addr, st_addr;
  logic        idata_valid, idata_ready, fdata_valid, fdata_ready;
  logic        ld_valid, ld_replay, ld_proceed, st_valid, st_ready, st_is_fp;

  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  store_addr_queue u0 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_is_fp(enq_is_fp), .commit(commit), .flush(flush),
    .idata_valid(idata_valid), .idata_ready(idata_ready),
    .fdata_valid(fdata_valid), .fdata_ready(fdata_ready),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_replay(ld_replay),
    .ld_proceed(ld_proceed), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_is_fp(st_is_fp)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        enq;
    logic [31:0] ea;
    logic        efp;
    logic        cm;
    logic        fl;
    logic        iv;
    logic        fv;
    logic        sr;
    logic [31:0] la;
    logic        xrdy;
    logic        xsv;
    logic [31:0] xsa;
    logic        xsfp;
    logic        xip;
    logic        xfp;
    logic        xrep;
  } vec_t;

  localparam int NV = 17;
  // Each row is one cycle: inputs, then outputs expected before that edge.
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0100, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R1 empty
    '{4'd7, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1000, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R7 same-cycle enq invisible
    '{4'd6, 1'b1, 32'h2008, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1004, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1}, // R6 in-granule hit
    '{4'd7, 1'b1, 32'h3000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1008, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R7 next granule
    '{4'd4, 1'b1, 32'h4000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h400C, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R4 wrong queue
    '{4'd2, 1'b1, 32'h5000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R2 full
    '{4'd3, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h5000, 1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 head, R2 drop
    '{4'd5, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h3004, 1'b0, 1'b1, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 int pop
    '{4'd5, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1000, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R5 no pop
    '{4'd9, 1'b1, 32'h6000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h4004, 1'b1, 1'b1, 32'h2008, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 flush
    '{4'd9, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h4004, 1'b1, 1'b1, 32'h2008, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 kept
    '{4'd8, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h6000, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R8 idle commit
    '{4'd8, 1'b1, 32'h7000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7000, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R8 commit with enq
    '{4'd8, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h7007, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b1}, // R8 still open
    '{4'd4, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h7008, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R4 commit edge
    '{4'd5, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h7000, 1'b1, 1'b1, 32'h7000, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 fp pop
    '{4'd1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7000, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 1'b0}  // R1 empty again
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    enq_valid = 0; enq_addr = '0; enq_is_fp = 0; commit = 0; flush = 0;
    idata_valid = 0; fdata_valid = 0; st_ready = 0; ld_valid = 0; ld_addr = '0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    enq_valid = v.enq; enq_addr = v.ea; enq_is_fp = v.efp; commit = v.cm; flush = v.fl;
    idata_valid = v.iv; fdata_valid = v.fv; st_ready = v.sr;
    ld_valid = 1'b1; ld_addr = v.la;
    #1;
    chk(int'(v.req), "enq_ready", 32'(enq_ready), 32'(v.xrdy));
    chk(int'(v.req), "st_valid", 32'(st_valid), 32'(v.xsv));
    if (v.xsv) begin
      chk(int'(v.req), "st_addr", st_addr, v.xsa);
      chk(int'(v.req), "st_is_fp", 32'(st_is_fp), 32'(v.xsfp));
    end
    chk(int'(v.req), "idata_ready", 32'(idata_ready), 32'(v.xip));
    chk(int'(v.req), "fdata_ready", 32'(fdata_ready), 32'(v.xfp));
    chk(int'(v.req), "ld_replay", 32'(ld_replay), 32'(v.xrep));
    chk(int'(v.req), "ld_proceed", 32'(ld_proceed), 32'(!v.xrep));
  endtask

  initial begin
    #80000;
    nbad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ld_valid = 1; ld_addr = 32'h0;
    #1;
    // R1: reset state
    chk(1, "reset enq_ready", 32'(enq_ready), 32'd1);
    chk(1, "reset st_valid", 32'(st_valid), 32'd0);
    chk(1, "reset ld_proceed", 32'(ld_proceed), 32'd1);

    for (int k = 0; k < NV; k++) apply(TBL[k]);

    // R3 / R2: fill across the pointer wrap, committing as we go.
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idle();
      enq_valid = 1; enq_addr = 32'h8000 + 32'(16 * k); enq_is_fp = k[0]; commit = 1;
      #1;
      chk(2, "fill enq_ready", 32'(enq_ready), 32'd1);
    end
    @(negedge clk);
    idle();
    commit = 1;
    #1;
    chk(2, "full enq_ready", 32'(enq_ready), 32'd0);
    // R6: no load presented, no verdict
    ld_valid = 0; ld_addr = 32'h8000;
    #0.5;
    chk(6, "idle ld_replay", 32'(ld_replay), 32'd0);
    chk(6, "idle ld_proceed", 32'(ld_proceed), 32'd0);
    ld_valid = 1; ld_addr = 32'h8034;
    #0.2;
    chk(6, "tail hit ld_replay", 32'(ld_replay), 32'd1);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idle();
      idata_valid = 1; fdata_valid = 1; st_ready = 1;
      #1;
      chk(3, "drain st_valid", 32'(st_valid), 32'd1);
      chk(3, "drain st_addr", st_addr, 32'h8000 + 32'(16 * k));
      chk(3, "drain st_is_fp", 32'(st_is_fp), 32'(k[0]));
      chk(5, "drain idata_ready", 32'(idata_ready), 32'(!k[0]));
      chk(5, "drain fdata_ready", 32'(fdata_ready), 32'(k[0]));
    end
    @(negedge clk);
    idle();
    idata_valid = 1; fdata_valid = 1; st_ready = 1;
    #1;
    chk(3, "drained st_valid", 32'(st_valid), 32'd0);
    chk(2, "drained enq_ready", 32'(enq_ready), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule